// File: doc/BRIEF.md
# FIR run control and bank swap

This block supervises a 128-word coefficient memory for a FIR engine. It holds the control word, qualifies the reset input and decides when filtering begins. It also chooses which coefficient bank is active and turns the tap length, the single or dual filter arrangement, the active bank and the filter A/B select into a coefficient base address.

Filtering can start in one of two ways. In self-load mode with free-run set, it starts as soon as the coefficients are loaded. In every other case it waits for the enable input, and the first sample is captured on that enable's clock edge. Bank requests come from a register bit or from a synchronized pin. A request is applied only on a sample-clock active edge, so a sample never sees two coefficient sets. The datapath and the coefficient loader sit outside this block.

Top module: `fir_run_ctrl`

## Requirements
- R1: A reset takes effect only after `rst_ni` has been sampled low on at least 16 consecutive rising edges. A low pulse of 15 cycles changes no output and no state.
- R2: After a qualified reset, `ctrl_o` is 0x8C80 and `run_o`, `bank_o`, `swap_done_o` and `coef_base_o` are all 0. In this state the filter is single, its taps code is 00 (128 taps), and the bank source is the register bit.
- R3: With `self_load_i` and `free_run_i` both high, `run_o` rises in the cycle after the first edge that samples `load_done_i` high.
- R4: In any other case, `run_o` rises in the cycle after an edge that samples `enable_i` and `load_done_i` both high. `enable_i` without `load_done_i` does not start the filter, and neither does `free_run_i` in host-load mode.
- R5: Once high, `run_o` stays high until a qualified reset, whatever `enable_i` and `free_run_i` do.
- R6: When control bit 7 is 1, the requested bank is control bit 6. When bit 7 is 0, the requested bank is the synchronized `swap_pin_i` and bit 6 is ignored. A request of 0 selects the lower bank and 1 selects the upper bank.
- R7: `bank_o` changes only in the cycle after an edge that samples `samp_edge_i` high.
- R8: `swap_done_o` is high for exactly the cycle after a sample edge at which `bank_o` changed, and is low otherwise.
- R9: Two modes disallow swaps: taps code 00, and dual mode with taps code 01. In these modes a sample edge forces `bank_o` to 0 and bank requests are ignored.
- R10: In single mode (control bit 0 = 0), `coef_base_o` is bank × L. Here L is 128, 64, 32 or 16 for taps code (control bits 9:8) 00, 01, 10 or 11, and `filt_b_i` has no effect.
- R11: In dual mode (control bit 0 = 1), `coef_base_o` is bank × 2L + `filt_b_i` × L, and dual with code 00 behaves as code 01. The results are: dual 64 puts A at 0 and B at 64; dual 32 gives 0/32/64/96; dual 16 gives 0/16/32/48, each listed as A lower, B lower, A upper, B upper.
- R12: An edge with `ctrl_wr_i` high loads `ctrl_wdata_i` into the control word, and the new value is visible on `ctrl_o` in the next cycle.
- R13: `swap_pin_i` passes through two synchronizing flops. A sample edge that arrives on the first edge after the pin changes still uses the old pin value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset request, length-qualified |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word write data |
| self_load_i | input | 1 | 1 = coefficients self-loaded, 0 = host-loaded |
| load_done_i | input | 1 | Coefficient loading complete |
| free_run_i | input | 1 | Start without waiting for enable (self-load only) |
| enable_i | input | 1 | Start request aligned with the first valid sample |
| swap_pin_i | input | 1 | Asynchronous bank request pin |
| samp_edge_i | input | 1 | Sample-clock active-edge strobe |
| filt_b_i | input | 1 | Address filter B instead of A (dual mode) |
| run_o | output | 1 | Filtering started |
| ctrl_o | output | 16 | Current control word |
| bank_o | output | 1 | Active bank, 0 lower, 1 upper |
| coef_base_o | output | 7 | Coefficient base address |
| swap_done_o | output | 1 | Bank changed at the last sample edge |

## Verification
The assertions assume that `samp_edge_i` is a single-cycle strobe aligned to the system clock. They also assume that `enable_i` stays low until loading is complete. The stimulus drives every input one time unit after a falling edge and raises `enable_i` only as a deliberate test that loading gates it. Each reset request is held for either 15 or at least 16 cycles, so the reset boundary is tested on both sides. The pin is held stable for at least three edges before the sample edge that should take it, except in the one case that tests the synchronizer delay.

// File: rtl/fir_rc_pkg.sv
package fir_rc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    TAPS_128 = 2'b00,
    TAPS_64  = 2'b01,
    TAPS_32  = 2'b10,
    TAPS_16  = 2'b11
  } taps_e;

  localparam int DUAL_BIT = 0;
  localparam int REG_SWAP_BIT = 6;
  localparam int SRC_REG_BIT = 7;
  localparam int TAP_LSB = 8;

  function automatic logic swap_allowed(taps_e taps, logic dual);
    return !(taps == TAPS_128 || (dual && taps == TAPS_64));
  endfunction
endpackage

// File: rtl/fir_rc_rst_qual.sv
module fir_rc_rst_qual #(
  parameter int RST_MIN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_act_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(RST_MIN);

  logic [CW-1:0] low_cnt_q;

  // counts sampled-low cycles, saturating; cleared while request is high
  always_ff @(posedge clk_i) begin
    if (rst_ni) low_cnt_q <= '0;
    else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign rst_act_o = (low_cnt_q == CNT_MAX);
endmodule

// File: rtl/fir_rc_bank.sv
module fir_rc_bank #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic swap_pin_i,
  input  logic src_reg_i,
  input  logic reg_swap_i,
  input  logic swap_ok_i,
  input  logic samp_edge_i,
  output logic bank_o,
  output logic swap_done_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_s, req, bank_nxt, bank_q, done_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q <= '0;
    else sync_q <= {sync_q[SYNC_STAGES-2:0], swap_pin_i};
  end

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign req      = src_reg_i ? reg_swap_i : pin_s;
  assign bank_nxt = swap_ok_i & req;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bank_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= samp_edge_i && (bank_nxt != bank_q);
      if (samp_edge_i) bank_q <= bank_nxt;
    end
  end

  assign bank_o      = bank_q;
  assign swap_done_o = done_q;
endmodule

// File: rtl/fir_rc_addr.sv
module fir_rc_addr
  import fir_rc_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  taps_e             taps_i,
  input  logic              dual_i,
  input  logic              bank_i,
  input  logic              filt_b_i,
  output logic [ADDR_W-1:0] base_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [ADDR_W:0] len, base_w;
  int sh;

  always_comb begin
    sh = ADDR_W - int'(taps_i);
    if (dual_i && taps_i == TAPS_128) sh = ADDR_W - 1;
    len = (ADDR_W + 1)'(1) << sh;
    base_w = '0;
    if (bank_i) base_w = dual_i ? (len << 1) : len;
    if (dual_i && filt_b_i) base_w = base_w + len;
  end

  // truncation maps a stale upper bank in a no-swap mode back onto bank 0
  assign base_o = base_w[ADDR_W-1:0];
endmodule

// File: rtl/fir_run_ctrl.sv
module fir_run_ctrl
  import fir_rc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CTRL_W = 16,
  parameter logic [CTRL_W-1:0] CTRL_RST = 16'h8C80,
  parameter int RST_MIN = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              self_load_i,
  input  logic              load_done_i,
  input  logic              free_run_i,
  input  logic              enable_i,
  input  logic              swap_pin_i,
  input  logic              samp_edge_i,
  input  logic              filt_b_i,
  output logic              run_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              bank_o,
  output logic [ADDR_W-1:0] coef_base_o,
  output logic              swap_done_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic rst_act, run_q, start, dual, swap_ok;
  logic [CTRL_W-1:0] ctrl_q;
  taps_e taps;

  fir_rc_rst_qual #(.RST_MIN(RST_MIN)) rst_qual_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rst_act_o(rst_act)
  );

  always_ff @(posedge clk_i) begin
    if (rst_act) ctrl_q <= CTRL_RST;
    else if (ctrl_wr_i) ctrl_q <= ctrl_wdata_i;
  end

  assign taps    = taps_e'(ctrl_q[TAP_LSB +: 2]);
  assign dual    = ctrl_q[DUAL_BIT];
  assign swap_ok = swap_allowed(taps, dual);

  assign start = load_done_i && ((free_run_i && self_load_i) || enable_i);

  always_ff @(posedge clk_i) begin
    if (rst_act) run_q <= 1'b0;
    else if (start) run_q <= 1'b1;
  end

  fir_rc_bank #(.SYNC_STAGES(SYNC_STAGES)) bank_i (
    .clk_i      (clk_i),
    .rst_i      (rst_act),
    .swap_pin_i (swap_pin_i),
    .src_reg_i  (ctrl_q[SRC_REG_BIT]),
    .reg_swap_i (ctrl_q[REG_SWAP_BIT]),
    .swap_ok_i  (swap_ok),
    .samp_edge_i(samp_edge_i),
    .bank_o     (bank_o),
    .swap_done_o(swap_done_o)
  );

  fir_rc_addr #(.ADDR_W(ADDR_W)) addr_i (
    .taps_i  (taps),
    .dual_i  (dual),
    .bank_i  (bank_o),
    .filt_b_i(filt_b_i),
    .base_o  (coef_base_o)
  );

  assign run_o  = run_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/fir_run_ctrl_chk.sv
module fir_run_ctrl_chk #(
  parameter int ADDR_W = 7,
  parameter int CTRL_W = 16,
  parameter logic [CTRL_W-1:0] CTRL_RST = 16'h8C80,
  parameter int RST_MIN = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_wr_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic              load_done_i,
  input logic              samp_edge_i,
  input logic              run_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              bank_o,
  input logic [ADDR_W-1:0] coef_base_o,
  input logic              swap_done_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(RST_MIN + 1);
  logic [CW-1:0] lo_c;
  logic rst_hit, no_swap;

  always_ff @(posedge clk_i) begin
    if (rst_ni) lo_c <= '0;
    else if (int'(lo_c) < RST_MIN) lo_c <= lo_c + 1'b1;
  end
  assign rst_hit = (int'(lo_c) >= RST_MIN);
  assign no_swap = (ctrl_o[9:8] == 2'b00) || (ctrl_o[0] && ctrl_o[9:8] == 2'b01);

  AST_RST_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_hit |=> (ctrl_o == CTRL_RST && !run_o && !bank_o)); // R2
  AST_NO_START_UNLOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !load_done_i && !rst_hit) |=> !run_o); // R4
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !rst_hit) |=> run_o); // R5
  AST_BANK_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!samp_edge_i && !rst_hit) |=> $stable(bank_o)); // R7
  AST_DONE_MEANS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_done_o |-> (bank_o != $past(bank_o))); // R8
  AST_NO_SWAP_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_edge_i && no_swap && !rst_hit) |=> !bank_o); // R9
  AST_BASE_SINGLE_128: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[9:8] == 2'b00 && !ctrl_o[0]) |-> (coef_base_o == '0)); // R10
  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !rst_hit) |=> (ctrl_o == $past(ctrl_wdata_i))); // R12
endmodule

bind fir_run_ctrl fir_run_ctrl_chk #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .CTRL_RST(CTRL_RST), .RST_MIN(RST_MIN)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_wr_i   (ctrl_wr_i),
  .ctrl_wdata_i(ctrl_wdata_i),
  .load_done_i (load_done_i),
  .samp_edge_i (samp_edge_i),
  .run_o       (run_o),
  .ctrl_o      (ctrl_o),
  .bank_o      (bank_o),
  .coef_base_o (coef_base_o),
  .swap_done_o (swap_done_o)
);

// File: tb/fir_run_ctrl_tb_top.sv
module fir_run_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SIG_RUN = 0, SIG_BANK = 1, SIG_CTRL = 2, SIG_BASE = 3, SIG_DONE = 4;

  typedef struct {
    int          cyc;
    int          sig;
    logic [15:0] val;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic ctrl_wr_i = 1'b0;
  logic [15:0] ctrl_wdata_i = '0;
  logic self_load_i = 1'b0, load_done_i = 1'b0, free_run_i = 1'b0, enable_i = 1'b0;
  logic swap_pin_i = 1'b0, samp_edge_i = 1'b0, filt_b_i = 1'b0;
  logic run_o, bank_o, swap_done_o;
  logic [15:0] ctrl_o;
  logic [6:0] coef_base_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fir_run_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .self_load_i(self_load_i), .load_done_i(load_done_i), .free_run_i(free_run_i),
    .enable_i(enable_i), .swap_pin_i(swap_pin_i), .samp_edge_i(samp_edge_i),
    .filt_b_i(filt_b_i), .run_o(run_o), .ctrl_o(ctrl_o), .bank_o(bank_o),
    .coef_base_o(coef_base_o), .swap_done_o(swap_done_o)
  );

  // monitor: compare every expectation due this cycle
  always @(negedge clk) begin
    exp_t it;
    logic [15:0] act;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      case (it.sig)
        SIG_RUN:  act = {15'd0, run_o};
        SIG_BANK: act = {15'd0, bank_o};
        SIG_CTRL: act = ctrl_o;
        SIG_BASE: act = {9'd0, coef_base_o};
        default:  act = {15'd0, swap_done_o};
      endcase
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s sig=%0d cycle=%0d actual=0x%0h expected=0x%0h",
                 it.req, it.sig, cyc, act, it.val);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_at(int sig, logic [15:0] val, string req);
    q.push_back('{cyc + 1, sig, val, req});
  endtask

  task automatic wr(logic [15:0] v);
    ctrl_wr_i = 1'b1;
    ctrl_wdata_i = v;
    expect_at(SIG_CTRL, v, "R12");
    step();
    ctrl_wr_i = 1'b0;
  endtask

  task automatic samp(logic exp_bank, logic exp_done, string req);
    samp_edge_i = 1'b1;
    expect_at(SIG_BANK, {15'd0, exp_bank}, req);
    expect_at(SIG_DONE, {15'd0, exp_done}, "R8");
    step();
    samp_edge_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_ni = 1'b0;
    repeat (20) step();
    rst_ni = 1'b1;
    expect_at(SIG_CTRL, 16'h8C80, "R2");
    expect_at(SIG_RUN, 16'd0, "R2");
    expect_at(SIG_BANK, 16'd0, "R2");
    expect_at(SIG_DONE, 16'd0, "R2");
    expect_at(SIG_BASE, 16'd0, "R2");
    step();

    // register-sourced swap, single 64 taps
    wr(16'h0180);
    expect_at(SIG_BASE, 16'd0, "R10");
    step();
    wr(16'h01C0);
    expect_at(SIG_BANK, 16'd0, "R7");
    step();
    expect_at(SIG_BANK, 16'd0, "R7");
    step();
    samp(1'b1, 1'b1, "R6");
    expect_at(SIG_DONE, 16'd0, "R8");
    expect_at(SIG_BASE, 16'd64, "R10");
    step();
    wr(16'h02C0);
    filt_b_i = 1'b1;
    expect_at(SIG_BASE, 16'd32, "R10");
    step();
    wr(16'h03C0);
    expect_at(SIG_BASE, 16'd16, "R10");
    step();

    // dual layouts, bank upper
    filt_b_i = 1'b0;
    wr(16'h02C1);
    expect_at(SIG_BASE, 16'd64, "R11");
    step();
    filt_b_i = 1'b1;
    expect_at(SIG_BASE, 16'd96, "R11");
    step();
    wr(16'h03C1);
    expect_at(SIG_BASE, 16'd48, "R11");
    step();
    filt_b_i = 1'b0;
    expect_at(SIG_BASE, 16'd32, "R11");
    step();
    wr(16'h0381);
    samp(1'b0, 1'b1, "R6");
    expect_at(SIG_BASE, 16'd0, "R11");
    step();
    filt_b_i = 1'b1;
    expect_at(SIG_BASE, 16'd16, "R11");
    step();

    // modes that disallow swaps
    wr(16'h01C0);
    samp(1'b1, 1'b1, "R6");
    wr(16'h00C0);
    samp(1'b0, 1'b1, "R9");
    wr(16'h01C1);
    samp(1'b0, 1'b0, "R9");
    expect_at(SIG_BASE, 16'd64, "R11");
    step();

    // pin-sourced swap through synchronizer
    wr(16'h0100);
    swap_pin_i = 1'b1;
    samp(1'b0, 1'b0, "R13");
    step(); step();
    samp(1'b1, 1'b1, "R6");
    wr(16'h0140);
    swap_pin_i = 1'b0;
    step(); step(); step();
    samp(1'b0, 1'b1, "R6");

    // run control
    enable_i = 1'b1;
    expect_at(SIG_RUN, 16'd0, "R4");
    step();
    enable_i = 1'b0;
    load_done_i = 1'b1;
    free_run_i = 1'b1;
    expect_at(SIG_RUN, 16'd0, "R4");
    step();
    enable_i = 1'b1;
    expect_at(SIG_RUN, 16'd1, "R4");
    step();
    enable_i = 1'b0;
    free_run_i = 1'b0;
    load_done_i = 1'b0;
    step();
    expect_at(SIG_RUN, 16'd1, "R5");
    step();

    // short reset pulse is ignored
    rst_ni = 1'b0;
    repeat (15) step();
    rst_ni = 1'b1;
    expect_at(SIG_CTRL, 16'h0140, "R1");
    expect_at(SIG_RUN, 16'd1, "R1");
    step();
    step();

    // qualified reset of exactly 16 cycles, then self-load free-run start
    self_load_i = 1'b1;
    free_run_i = 1'b1;
    rst_ni = 1'b0;
    repeat (16) step();
    rst_ni = 1'b1;
    expect_at(SIG_CTRL, 16'h8C80, "R1");
    expect_at(SIG_RUN, 16'd0, "R1");
    step();
    expect_at(SIG_RUN, 16'd0, "R3");
    step();
    load_done_i = 1'b1;
    expect_at(SIG_RUN, 16'd1, "R3");
    step();
    step(); step();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule